// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox Messaging Unit

This unit carries short messages between a host processor and an embedded firmware processor. Each processor has its own register port. It also has an outgoing channel with a 16-word mailbox, a 32-bit doorbell word and a pair of handshake flags. Its peer sees that channel as incoming. A sender fills the outgoing mailbox and then writes a command word into the doorbell. That write raises an interrupt toward the peer and clears both flags in the sender's status view. The peer reads the doorbell, which drops its interrupt and sets Ready back in the sender's view. Once it has consumed the mailbox, the peer writes a 1 to the Done position of its incoming status register. The next message may go out only when both flags are set again.

The handshake is driven entirely by side effects of ordinary register accesses, so neither processor needs a polling loop to keep the flags consistent. The register ports have no back-pressure. Every access completes in the cycle its enable is high, and read data comes back one cycle later.

Per-side byte map: 0x00–0x3C outgoing mailbox (write only), 0x40–0x7C incoming mailbox (read only), 0x80 outgoing doorbell (write), 0x84 outgoing status (read), 0x88 incoming doorbell (read), 0x8C incoming status (read, write bit 1 to set Done). Status bit 0 is Ready and bit 1 is Done.

Top module: `ipc_mailbox_unit`

## Requirements
- R1: After reset every status view reads 0x3 (Ready in bit 0 and Done in bit 1 both set), both interrupt outputs are low and both read-data ports are zero.
- R2: A doorbell write at 0x80 while the sender's Ready and Done are both set stores the full word. It raises the interrupt toward the peer (host to firmware on irq_fw, firmware to host on irq_host) and clears both flags, so the sender's status at 0x84 then reads 0x0.
- R3: A doorbell write at 0x80 while Ready or Done is clear is dropped: the stored doorbell word, the flags and the interrupt keep their values.
- R4: A read of the incoming doorbell at 0x88 returns all 32 bits unchanged, with bit 31 (response marker) included. It clears the interrupt toward the reader and sets Ready (bit 0) in the sender's view.
- R5: A write to the incoming status at 0x8C with bit 1 high sets Done in the sender's view. With bit 1 low it has no effect, bit 0 of the write is ignored, and Ready is set only by a doorbell read.
- R6: Words written by a sender at byte offsets 0x00–0x3C (word index = offset/4) are returned to the peer at 0x40–0x7C with the same index, separately for each direction.
- R7: A read of a side's own outgoing mailbox range returns zero, and a write into its incoming mailbox range changes nothing.
- R8: Read data appears in the cycle after the read enable and is zero in a cycle that follows no read. Unaligned addresses (low two bits non-zero) and unmapped offsets read zero and ignore writes.
- R9: The two directions are independent: traffic in one never changes the other direction's flags, doorbell, mailbox or interrupt.
- R10: Each interrupt is a level that stays high from the accepted doorbell write until the peer's doorbell read, whatever other accesses happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_rd |
| fw_addr | input | 8 | Firmware byte address |
| fw_wr | input | 1 | Firmware write enable |
| fw_rd | input | 1 | Firmware read enable |
| fw_wdata | input | 32 | Firmware write data |
| fw_rdata | output | 32 | Firmware read data, one cycle after fw_rd |
| irq_host | output | 1 | Level interrupt toward the host (firmware-to-host doorbell pending) |
| irq_fw | output | 1 | Level interrupt toward the firmware (host-to-firmware doorbell pending) |

## Verification
The assertions run on every cycle. They check that each interrupt edge and each rise of a Ready or Done flag is caused by the matching doorbell or status access in the previous cycle. They also check that an interrupt is always the complement of its channel's Ready flag, that a gated doorbell write never raises an interrupt, and that read data is zero after an idle cycle. The scenarios must still show the data itself: mailbox contents arriving under the right index, the doorbell word with bit 31 passing through unchanged, wrong-side and unaligned accesses having no effect, and the two directions staying apart under interleaved random traffic.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  // byte offsets inside the control window (which follows both mailboxes)
  localparam int CTRL_DB_OUT = 0;
  localparam int CTRL_ST_OUT = 4;
  localparam int CTRL_DB_IN  = 8;
  localparam int CTRL_ST_IN  = 12;

  // status word bit positions
  localparam int FLAG_RDY  = 0;
  localparam int FLAG_DONE = 1;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MB_OUT,
    ACC_MB_IN,
    ACC_DB_OUT,
    ACC_ST_OUT,
    ACC_DB_IN,
    ACC_ST_IN
  } acc_kind_e;

endpackage

// File: rtl/ipc_side_decode.sv
module ipc_side_decode
  import ipc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int MB_WORDS = 16,
  localparam int IDX_W   = $clog2(MB_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic              mb_wr,
  output logic              db_wr,
  output logic              st_wr,
  output logic              db_rd
);

  localparam int MB_BYTES = MB_WORDS * 4;

  logic [ADDR_W-1:0] ctrl_off;

  assign ctrl_off = addr - ADDR_W'(2 * MB_BYTES);
  assign idx      = addr[IDX_W+1:2];

  always_comb begin
    kind = ACC_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr < ADDR_W'(MB_BYTES))             kind = ACC_MB_OUT;
      else if (addr < ADDR_W'(2 * MB_BYTES))    kind = ACC_MB_IN;
      else if (ctrl_off == ADDR_W'(CTRL_DB_OUT)) kind = ACC_DB_OUT;
      else if (ctrl_off == ADDR_W'(CTRL_ST_OUT)) kind = ACC_ST_OUT;
      else if (ctrl_off == ADDR_W'(CTRL_DB_IN))  kind = ACC_DB_IN;
      else if (ctrl_off == ADDR_W'(CTRL_ST_IN))  kind = ACC_ST_IN;
    end
  end

  assign mb_wr = wr && (kind == ACC_MB_OUT);
  assign db_wr = wr && (kind == ACC_DB_OUT);
  assign st_wr = wr && (kind == ACC_ST_IN);
  assign db_rd = rd && (kind == ACC_DB_IN);

endmodule

// File: rtl/ipc_channel.sv
module ipc_channel #(
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 16,
  localparam int IDX_W   = $clog2(MB_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  // sender side
  input  logic              snd_mb_wr,
  input  logic [IDX_W-1:0]  snd_idx,
  input  logic [DATA_W-1:0] snd_wdata,
  input  logic              snd_db_wr,
  // receiver side
  input  logic              rcv_db_rd,
  input  logic              rcv_done_set,
  input  logic [IDX_W-1:0]  rcv_idx,
  output logic [DATA_W-1:0] rcv_mb_rdata,
  // state
  output logic [DATA_W-1:0] db_word,
  output logic              ready,
  output logic              done,
  output logic              irq
);

  logic [DATA_W-1:0] mem [MB_WORDS];
  logic              db_ok;

  assign db_ok = snd_db_wr && ready && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MB_WORDS; i++) mem[i] <= '0;
    end else if (snd_mb_wr) begin
      mem[snd_idx] <= snd_wdata;
    end
  end

  assign rcv_mb_rdata = mem[rcv_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_word <= '0;
      ready   <= 1'b1;
      done    <= 1'b1;
      irq     <= 1'b0;
    end else if (db_ok) begin
      db_word <= snd_wdata;
      ready   <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b1;
    end else begin
      if (rcv_db_rd) begin
        irq   <= 1'b0;
        ready <= 1'b1;
      end
      if (rcv_done_set) done <= 1'b1;
    end
  end

endmodule

// File: rtl/ipc_mailbox_unit.sv
module ipc_mailbox_unit
  import ipc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic              fw_wr,
  input  logic              fw_rd,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] fw_rdata,
  output logic              irq_host,
  output logic              irq_fw
);

  localparam int IDX_W = $clog2(MB_WORDS);
  localparam int NSIDE = 2;

  // side 0 = host, side 1 = firmware; channel d carries side d -> side 1-d
  logic [ADDR_W-1:0] bus_addr  [NSIDE];
  logic              bus_wr    [NSIDE];
  logic              bus_rd    [NSIDE];
  logic [DATA_W-1:0] bus_wdata [NSIDE];
  logic [DATA_W-1:0] rdata_q   [NSIDE];

  acc_kind_e         kind   [NSIDE];
  logic [IDX_W-1:0]  idx    [NSIDE];
  logic              mb_wr  [NSIDE];
  logic              db_wr  [NSIDE];
  logic              st_wr  [NSIDE];
  logic              db_rd  [NSIDE];

  logic [DATA_W-1:0] ch_mb_rdata [NSIDE];
  logic [DATA_W-1:0] ch_db       [NSIDE];
  logic [NSIDE-1:0]  ch_ready;
  logic [NSIDE-1:0]  ch_done;
  logic [NSIDE-1:0]  ch_irq;

  assign bus_addr[0]  = host_addr;
  assign bus_wr[0]    = host_wr;
  assign bus_rd[0]    = host_rd;
  assign bus_wdata[0] = host_wdata;
  assign bus_addr[1]  = fw_addr;
  assign bus_wr[1]    = fw_wr;
  assign bus_rd[1]    = fw_rd;
  assign bus_wdata[1] = fw_wdata;

  assign host_rdata = rdata_q[0];
  assign fw_rdata   = rdata_q[1];
  assign irq_fw     = ch_irq[0];
  assign irq_host   = ch_irq[1];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int PEER = 1 - s;

    ipc_side_decode #(
      .ADDR_W  (ADDR_W),
      .MB_WORDS(MB_WORDS)
    ) u_dec (
      .addr (bus_addr[s]),
      .wr   (bus_wr[s]),
      .rd   (bus_rd[s]),
      .kind (kind[s]),
      .idx  (idx[s]),
      .mb_wr(mb_wr[s]),
      .db_wr(db_wr[s]),
      .st_wr(st_wr[s]),
      .db_rd(db_rd[s])
    );

    ipc_channel #(
      .DATA_W  (DATA_W),
      .MB_WORDS(MB_WORDS)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .snd_mb_wr   (mb_wr[s]),
      .snd_idx     (idx[s]),
      .snd_wdata   (bus_wdata[s]),
      .snd_db_wr   (db_wr[s]),
      .rcv_db_rd   (db_rd[PEER]),
      .rcv_done_set(st_wr[PEER] && bus_wdata[PEER][FLAG_DONE]),
      .rcv_idx     (idx[PEER]),
      .rcv_mb_rdata(ch_mb_rdata[s]),
      .db_word     (ch_db[s]),
      .ready       (ch_ready[s]),
      .done        (ch_done[s]),
      .irq         (ch_irq[s])
    );

    // read path: data for side s, registered one cycle after the enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata_q[s] <= '0;
      end else if (bus_rd[s]) begin
        case (kind[s])
          ACC_MB_IN:  rdata_q[s] <= ch_mb_rdata[PEER];
          ACC_DB_IN:  rdata_q[s] <= ch_db[PEER];
          ACC_ST_OUT: rdata_q[s] <= {{(DATA_W-2){1'b0}}, ch_done[s], ch_ready[s]};
          ACC_ST_IN:  rdata_q[s] <= {{(DATA_W-2){1'b0}}, ch_done[PEER], ch_ready[PEER]};
          default:    rdata_q[s] <= '0;
        endcase
      end else begin
        rdata_q[s] <= '0;
      end
    end
  end

endmodule

// File: rtl/ipc_mailbox_unit_sva.sv
module ipc_mailbox_unit_sva #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_wr,
  input logic              h_rd,
  input logic              h_done_bit,
  input logic [DATA_W-1:0] h_rdata,
  input logic [ADDR_W-1:0] f_addr,
  input logic              f_wr,
  input logic              f_rd,
  input logic              f_done_bit,
  input logic [DATA_W-1:0] f_rdata,
  input logic              irq_host,
  input logic              irq_fw,
  input logic [1:0]        ch_ready,
  input logic [1:0]        ch_done
);

  localparam int BASE = 2 * MB_WORDS * 4;
  localparam logic [ADDR_W-1:0] A_DB_OUT = ADDR_W'(BASE + 0);
  localparam logic [ADDR_W-1:0] A_DB_IN  = ADDR_W'(BASE + 8);
  localparam logic [ADDR_W-1:0] A_ST_IN  = ADDR_W'(BASE + 12);

  // R2: an interrupt rises only after the sender's doorbell write
  p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fw) |-> $past(h_wr && h_addr == A_DB_OUT));
  p_irq_rise_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_host) |-> $past(f_wr && f_addr == A_DB_OUT));

  // R4: an interrupt falls only after the receiver's doorbell read
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_fw) |-> $past(f_rd && f_addr == A_DB_IN));
  p_irq_fall_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_host) |-> $past(h_rd && h_addr == A_DB_IN));

  // R5: Ready rises only from a doorbell read, Done only from a status write with bit 1
  p_ready_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_ready[0]) |-> $past(f_rd && f_addr == A_DB_IN));
  p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_done[0]) |-> $past(f_wr && f_addr == A_ST_IN && f_done_bit));
  p_done_src_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_done[1]) |-> $past(h_wr && h_addr == A_ST_IN && h_done_bit));

  // R3: a doorbell write with a flag clear never raises the interrupt
  p_gated_db_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_DB_OUT && !(ch_ready[0] && ch_done[0])) |=> !$rose(irq_fw));

  // R10: a pending interrupt and the sender's Ready are always opposite
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fw != ch_ready[0]) && (irq_host != ch_ready[1]));

  // R8: read data is zero after a cycle without a read
  p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(h_rd) |-> h_rdata == '0);
  p_rdata_idle_fw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(f_rd) |-> f_rdata == '0);

endmodule

bind ipc_mailbox_unit ipc_mailbox_unit_sva #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .MB_WORDS(MB_WORDS)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_addr    (host_addr),
  .h_wr      (host_wr),
  .h_rd      (host_rd),
  .h_done_bit(host_wdata[1]),
  .h_rdata   (host_rdata),
  .f_addr    (fw_addr),
  .f_wr      (fw_wr),
  .f_rd      (fw_rd),
  .f_done_bit(fw_wdata[1]),
  .f_rdata   (fw_rdata),
  .irq_host  (irq_host),
  .irq_fw    (irq_fw),
  .ch_ready  (ch_ready),
  .ch_done   (ch_done)
);

// File: tb/ipc_mailbox_unit_bench.sv
module ipc_mailbox_unit_bench;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int MB_WORDS = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0, fw_addr = '0;
  logic              host_wr = 1'b0, host_rd = 1'b0, fw_wr = 1'b0, fw_rd = 1'b0;
  logic [DATA_W-1:0] host_wdata = '0, fw_wdata = '0;
  logic [DATA_W-1:0] host_rdata, fw_rdata;
  logic              irq_host, irq_fw;

  always #10 clk = ~clk;

  ipc_mailbox_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MB_WORDS(MB_WORDS)
  ) u_ipc_mailbox_unit (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fw_addr(fw_addr), .fw_wr(fw_wr), .fw_rd(fw_rd),
    .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
    .irq_host(irq_host), .irq_fw(irq_fw)
  );

  // model; direction d sends from side d (0 host, 1 firmware)
  logic [31:0] m_mb  [2][MB_WORDS];
  logic [31:0] m_db  [2];
  bit          m_rdy [2];
  bit          m_dn  [2];
  bit          m_irq [2];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int s, logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 8'h40)       return 32'h0;
    if (a < 8'h80)       return m_mb[1-s][a[5:2]];
    case (a)
      8'h84:   return {30'h0, m_dn[s], m_rdy[s]};
      8'h88:   return m_db[1-s];
      8'h8C:   return {30'h0, m_dn[1-s], m_rdy[1-s]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(logic [7:0] a);
    if (a[1:0] != 2'b00)        return "R8 unaligned";
    if (a < 8'h40)              return "R7 own outgoing mailbox";
    if (a < 8'h80)              return "R6 incoming mailbox";
    if (a == 8'h88)             return "R4 doorbell read";
    if (a == 8'h84 || a == 8'h8C) return "R5 status read";
    return "R8 unmapped";
  endfunction

  task automatic drive(int s, logic [7:0] a, bit w, bit r, logic [31:0] d);
    if (s == 0) begin
      host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    end else begin
      fw_addr = a; fw_wr = w; fw_rd = r; fw_wdata = d;
    end
  endtask

  task automatic bus_write(int s, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    drive(s, a, 1'b1, 1'b0, d);
    @(negedge clk);
    drive(s, 8'h0, 1'b0, 1'b0, 32'h0);
    if (a[1:0] == 2'b00) begin
      if (a < 8'h40) m_mb[s][a[5:2]] = d;
      else if (a == 8'h80 && m_rdy[s] && m_dn[s]) begin
        m_db[s] = d; m_rdy[s] = 0; m_dn[s] = 0; m_irq[s] = 1;
      end else if (a == 8'h8C && d[1]) m_dn[1-s] = 1;
    end
  endtask

  task automatic bus_read(int s, logic [7:0] a, string tag);
    logic [31:0] exp;
    exp = exp_read(s, a);
    @(negedge clk);
    drive(s, a, 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    drive(s, 8'h0, 1'b0, 1'b0, 32'h0);
    chk(tag, (s == 0) ? host_rdata : fw_rdata, exp);
    if (a == 8'h88) begin
      m_irq[1-s] = 0; m_rdy[1-s] = 1;
    end
  endtask

  task automatic chk_irq(string tag);
    chk({tag, " irq_fw"}, {31'h0, irq_fw}, {31'h0, m_irq[0]});
    chk({tag, " irq_host"}, {31'h0, irq_host}, {31'h0, m_irq[1]});
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    for (int d = 0; d < 2; d++) begin
      m_db[d] = '0; m_rdy[d] = 1; m_dn[d] = 1; m_irq[d] = 0;
      for (int i = 0; i < MB_WORDS; i++) m_mb[d][i] = '0;
    end
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 host_rdata", host_rdata, 32'h0);
    chk("R1 fw_rdata", fw_rdata, 32'h0);
    chk_irq("R1");
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(0, 8'h84, "R1 host status out");
    bus_read(0, 8'h8C, "R1 host status in");
    bus_read(1, 8'h84, "R1 fw status out");
    bus_read(1, 8'h8C, "R1 fw status in");

    // R6: host fills its outgoing mailbox, firmware reads it back
    for (int i = 0; i < MB_WORDS; i++) bus_write(0, 8'(i * 4), 32'hA500_0000 + 32'(i * 17));
    for (int i = 0; i < MB_WORDS; i++) bus_read(1, 8'(8'h40 + i * 4), "R6 mailbox word");
    // R7: wrong-side accesses
    bus_read(0, 8'h00, "R7 own outgoing read");
    bus_write(1, 8'h40, 32'hDEAD_BEEF);
    bus_read(1, 8'h40, "R7 inbound write dropped");
    bus_read(0, 8'h40, "R9 reverse mailbox untouched");

    // R2: doorbell with response marker in bit 31
    bus_write(0, 8'h80, 32'h8000_0005);
    chk_irq("R2 after doorbell");
    bus_read(0, 8'h84, "R2 flags cleared");
    // R10: status reads do not clear the interrupt
    bus_read(1, 8'h8C, "R10 receiver status");
    chk_irq("R10 still pending");
    // R4: doorbell read passes bit 31, clears irq, sets Ready
    bus_read(1, 8'h88, "R4 doorbell word");
    chk_irq("R4 after read");
    bus_read(0, 8'h84, "R4 ready only");
    // R3: blocked doorbell while Done clear
    bus_write(0, 8'h80, 32'h0000_0077);
    chk_irq("R3 blocked");
    bus_read(1, 8'h88, "R3 doorbell unchanged");
    // R5: bit0-only write has no effect, bit1 sets Done
    bus_write(1, 8'h8C, 32'h0000_0001);
    bus_read(0, 8'h84, "R5 bit0 ignored");
    bus_write(1, 8'h8C, 32'h0000_0002);
    bus_read(0, 8'h84, "R5 done set");
    // R9: reverse direction unaffected
    bus_read(1, 8'h84, "R9 fw status");
    // R8: unaligned, unmapped, idle cycle
    bus_read(0, 8'h85, "R8 unaligned");
    bus_read(0, 8'h90, "R8 unmapped");
    @(negedge clk);
    chk("R8 idle rdata", host_rdata, 32'h0);

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int s, op;
      logic [7:0] a;
      s  = int'($urandom % 2);
      op = int'($urandom % 9);
      case (op)
        0, 1: bus_write(s, 8'(($urandom % MB_WORDS) * 4), $urandom);
        2:    begin a = 8'(8'h40 + ($urandom % MB_WORDS) * 4); bus_read(s, a, tag_for(a)); end
        3:    bus_write(s, 8'h80, $urandom);
        4:    bus_read(s, 8'h88, "R4 doorbell read");
        5:    bus_write(s, 8'h8C, $urandom % 4);
        6:    begin a = ($urandom % 2 == 0) ? 8'h84 : 8'h8C; bus_read(s, a, tag_for(a)); end
        7:    begin a = 8'($urandom); bus_read(s, a, tag_for(a)); end
        default: begin
          a = 8'($urandom);
          if (a == 8'h80 || a == 8'h8C || a < 8'h40) a = 8'h40 + {2'b00, a[5:0]};
          bus_write(s, a, $urandom);
        end
      endcase
      chk_irq("R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule